// File: doc/BRIEF.md
# Dual-Modulus Clock Prescaler

The block divides its input clock by one of two adjacent ratios. Two mode-control inputs steer the choice. Either input high selects the lower ratio. Both inputs low select the higher ratio, which is the lower ratio plus one. A slower programmable counter can drive these inputs once per output cycle, and this "swallows" an extra input clock whenever it needs one. That is how pulse-swallowing synthesis reaches fine division steps while the fast stage stays this small.

A parameter selects the ratio pair: 10/11 by default, or 5/6 for the smaller variant. The mode is captured only at the terminal count, so a change never cuts a cycle short. An active-low count enable freezes the counter and the output. An active-low asynchronous master set forces a defined state at any time. The outputs are a true and a complementary divided clock.

Top module: `dm_prescaler`

## Requirements
- R1: With LOW_RATIO=10, each output period lasts 10 input clocks when at least one mode bit is high, and 11 input clocks when both mode bits are low.
- R2: The mode bits are OR-combined. Setting mode_a_i alone, mode_b_i alone, or both gives the lower ratio.
- R3: With LOW_RATIO=5, the same controls give periods of 5 and 6 input clocks.
- R4: The mode is sampled only on the rising edge that leaves the terminal count. A change anywhere inside a cycle, including the last clock before that edge, leaves the current period unchanged and applies to the next period.
- R5: In every period of N clocks, q_o is 1 for floor(N/2) clocks and 0 for the remaining clocks. It rises exactly once, at the start of the period.
- R6: While cnt_en_ni is 1, clock edges change neither the count nor q_o. A period that contains H held clocks lasts N+H clocks.
- R7: rst_ni low forces q_o=0 and q_n_o=1 at once, with no clock edge needed.
- R8: After rst_ni is released, the first rising edge with cnt_en_ni=0 makes q_o rise. That first period has the ratio selected by the mode bits at that edge.
- R9: q_n_o is always the inverse of q_o.
- R10: While rst_ni is low, clock edges leave q_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous master set, active low |
| mode_a_i | input | 1 | Mode bit A; 1 selects the lower ratio |
| mode_b_i | input | 1 | Mode bit B; 1 selects the lower ratio |
| cnt_en_ni | input | 1 | Count enable, active low |
| q_o | output | 1 | Divided output |
| q_n_o | output | 1 | Complement of q_o |

## Verification
The bench builds two instances side by side, one with LOW_RATIO=10 and one with LOW_RATIO=5, and drives them from the same inputs. The 5/6 instance exercises odd and even ratios with a very short high phase. The 10/11 instance leaves room to change the mode early, mid-cycle, and in the last clock before the terminal edge. Running both instances together shows that the enable, the master set and the mode latching behave the same whatever the ratio pair.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  typedef enum logic {MOD_LOW = 1'b0, MOD_HIGH = 1'b1} mod_e;
endpackage

// File: rtl/dmp_mode_sel.sv
module dmp_mode_sel
  import dmp_pkg::*;
(
  input  logic mode_a_i,
  input  logic mode_b_i,
  output mod_e sel_o
);
  // either bit high -> lower ratio
  assign sel_o = (mode_a_i | mode_b_i) ? MOD_LOW : MOD_HIGH;
endmodule

// File: rtl/dmp_counter.sv
module dmp_counter
  import dmp_pkg::*;
#(
  parameter int LOW_RATIO = 10,
  localparam int HIGH_RATIO = LOW_RATIO + 1,
  localparam int CW = $clog2(HIGH_RATIO + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  mod_e          sel_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic [CW-1:0] ratio_nxt_o
);
  localparam logic [CW-1:0] LoC = CW'(LOW_RATIO);
  localparam logic [CW-1:0] HiC = CW'(HIGH_RATIO);

  logic [CW-1:0] cnt_q, cnt_d, ratio_q, ratio_d;
  logic          tc;

  assign tc = (cnt_q == ratio_q - CW'(1));

  always_comb begin
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    if (en_i) begin
      if (tc) begin
        cnt_d   = '0;
        ratio_d = (sel_i == MOD_HIGH) ? HiC : LoC;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  // set state: terminal count of the high ratio, so the next enabled edge starts a cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= HiC - CW'(1);
      ratio_q <= HiC;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
    end
  end

  assign cnt_o       = cnt_q;
  assign cnt_nxt_o   = cnt_d;
  assign ratio_nxt_o = ratio_d;

  a_r5_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);
  a_r1_ratio_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q == LoC) || (ratio_q == HiC));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && $stable(ratio_q)));
  a_r4_ratio_at_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && tc) |=> $stable(ratio_q));
endmodule

// File: rtl/dmp_out_stage.sv
module dmp_out_stage #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_nxt_i,
  input  logic [CW-1:0] ratio_nxt_i,
  output logic          q_o,
  output logic          q_n_o
);
  logic q_q;

  // registered so the outputs carry no decode glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= (cnt_nxt_i < (ratio_nxt_i >> 1));
  end

  assign q_o   = q_q;
  assign q_n_o = ~q_q;
endmodule

// File: rtl/dm_prescaler.sv
module dm_prescaler
  import dmp_pkg::*;
#(
  parameter int LOW_RATIO = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_a_i,
  input  logic mode_b_i,
  input  logic cnt_en_ni,
  output logic q_o,
  output logic q_n_o
);
  localparam int CW = $clog2(LOW_RATIO + 2);

  mod_e          sel;
  logic [CW-1:0] cnt, cnt_nxt, ratio_nxt;

  dmp_mode_sel u_mode_sel (
    .mode_a_i (mode_a_i),
    .mode_b_i (mode_b_i),
    .sel_o    (sel)
  );

  dmp_counter #(.LOW_RATIO(LOW_RATIO)) u_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (!cnt_en_ni),
    .sel_i       (sel),
    .cnt_o       (cnt),
    .cnt_nxt_o   (cnt_nxt),
    .ratio_nxt_o (ratio_nxt)
  );

  dmp_out_stage #(.CW(CW)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_nxt_i   (cnt_nxt),
    .ratio_nxt_i (ratio_nxt),
    .q_o         (q_o),
    .q_n_o       (q_n_o)
  );

  a_r5_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> (cnt == '0));
  a_r6_out_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_ni |=> $stable(q_o));
endmodule

// File: tb/dm_prescaler_bench.sv
`timescale 1ns/1ps
module dm_prescaler_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_a = 1'b0, m_b = 1'b0, en_n = 1'b0;
  logic q_w [2];
  logic qn_w [2];
  int   n_chk = 0, n_err = 0;
  int   lo_r [2] = '{10, 5};

  always #2 clk = ~clk;

  dm_prescaler #(.LOW_RATIO(10)) u_dm_prescaler (
    .clk_i(clk), .rst_ni(rst_n), .mode_a_i(m_a), .mode_b_i(m_b),
    .cnt_en_ni(en_n), .q_o(q_w[0]), .q_n_o(qn_w[0]));
  dm_prescaler #(.LOW_RATIO(5)) u_dm_prescaler_small (
    .clk_i(clk), .rst_ni(rst_n), .mode_a_i(m_a), .mode_b_i(m_b),
    .cnt_en_ni(en_n), .q_o(q_w[1]), .q_n_o(qn_w[1]));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic sync_rise(input int idx);
    logic prev;
    prev = q_w[idx];
    for (int i = 0; i < 100; i++) begin
      step();
      if (q_w[idx] && !prev) return;
      prev = q_w[idx];
    end
    chk("sync", 0, 1);
  endtask

  // call right after q rose; measures the period that starts here
  task automatic count_period(input int idx, input int chg_at, input logic na, input logic nb,
                              input int hold_at, input int hold_len,
                              output int per, output int hi, output int bad);
    logic prev, held;
    per = 1; hi = 1; bad = 0; prev = 1'b1;
    for (int g = 0; g < 100; g++) begin
      if (per == chg_at) begin m_a = na; m_b = nb; end
      if (per == hold_at) begin
        en_n = 1'b1;
        held = q_w[idx];
        for (int h = 0; h < hold_len; h++) begin
          step();
          per++;
          if (q_w[idx] !== held) bad++;
          if (q_w[idx]) hi++;
        end
        en_n = 1'b0;
      end
      step();
      if (qn_w[idx] !== ~q_w[idx]) bad++;
      if (q_w[idx] && !prev) return;
      per++;
      if (q_w[idx]) hi++;
      prev = q_w[idx];
    end
  endtask

  task automatic t_reset_state();
    for (int i = 0; i < 2; i++) begin
      chk("R7 q in set", int'(q_w[i]), 0);
      chk("R9 qn in set", int'(qn_w[i]), 1);
    end
  endtask

  task automatic t_ratios(input int idx, input logic a, input logic b, input int n, input string req);
    int p, h, bd;
    m_a = a; m_b = b;
    sync_rise(idx);
    count_period(idx, 0, a, b, 0, 0, p, h, bd);  // flush a period latched earlier
    count_period(idx, 0, a, b, 0, 0, p, h, bd);
    chk({req, " period"}, p, n);
    chk("R5 high time", h, n / 2);
    chk("R9 complement", bd, 0);
  endtask

  task automatic t_midcycle_change();
    int p, h, bd;
    m_a = 0; m_b = 0;
    sync_rise(0);
    count_period(0, 0, 0, 0, 0, 0, p, h, bd);
    count_period(0, 3, 1, 0, 0, 0, p, h, bd);
    chk("R4 current period kept", p, 11);
    count_period(0, 10, 0, 0, 0, 0, p, h, bd);  // change in last clock
    chk("R4 new ratio next", p, 10);
    count_period(0, 0, 0, 0, 0, 0, p, h, bd);
    chk("R4 late change applied next", p, 11);
  endtask

  task automatic t_hold(input int idx);
    int p, h, bd, n;
    m_a = 1; m_b = 0;
    n = lo_r[idx];
    sync_rise(idx);
    count_period(idx, 0, 1, 0, 0, 0, p, h, bd);
    count_period(idx, 0, 1, 0, 1, 4, p, h, bd);
    chk("R6 held period", p, n + 4);
    chk("R6 held high", h, n / 2 + 4);
    chk("R6 frozen output", bd, 0);
  endtask

  task automatic t_master_set();
    int p, h, bd;
    m_a = 0; m_b = 1;
    sync_rise(0);
    #0.5 rst_n = 1'b0;
    #0.5;
    chk("R7 async q", int'(q_w[0]), 0);
    chk("R7 async qn", int'(qn_w[0]), 1);
    repeat (3) step();
    chk("R10 set holds", int'(q_w[0]) + int'(q_w[1]), 0);
    en_n = 1'b1;
    rst_n = 1'b1;
    repeat (2) step();
    chk("R8 waits for enable", int'(q_w[0]) + int'(q_w[1]), 0);
    m_b = 0;
    en_n = 1'b0;
    step();
    chk("R8 first edge rises", int'(q_w[0]) + int'(q_w[1]), 2);
    count_period(0, 0, 0, 0, 0, 0, p, h, bd);
    chk("R8 first period", p, 11);
  endtask

  initial begin
    #600000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #1;
    t_reset_state();
    repeat (2) step();
    rst_n = 1'b1;
    t_ratios(0, 0, 0, 11, "R1 both low");
    t_ratios(0, 1, 0, 10, "R2 bit a");
    t_ratios(0, 0, 1, 10, "R2 bit b");
    t_ratios(0, 1, 1, 10, "R1 both high");
    t_ratios(1, 0, 0, 6, "R3 both low");
    t_ratios(1, 1, 0, 5, "R3 bit a");
    t_midcycle_change();
    t_hold(0);
    t_hold(1);
    t_master_set();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule